// File: doc/BRIEF.md
# Fixed-Period Multi-Channel Pulse Width Generator

This block drives a small bank of pulse-width outputs. Software programs them through 8-bit registers on a plain byte-wide bus that has an address, write data, a write strobe and registered read data. Each channel has three settings. A 4-bit rate code sets the length of one time step, called a quantum, by dividing the input clock by 32 minus the code. A 10-bit duty field sets how many quanta of each period the output stays high. A bit in a shared enable register switches the channel on or off.

Every period lasts exactly 1024 quanta. The output is high for the first (duty + 1) quanta of the period and low for the rest. A channel therefore never produces zero duty while it runs; software gets a constantly low output by clearing the enable bit. The rate and duty values that software writes are copied into a working set when a channel starts and again at each period boundary. A write in the middle of a period therefore never shortens or splits a pulse.

The register map has one enable register at address 0. Channel n owns a pair of registers at addresses 1+2n and 2+2n. The channel count and the address width are parameters.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: The enable register sits at address 0, and bit n enables channel n. Channel n's duty low byte is at address 1+2n, bits [7:0]. At address 2+2n, duty bits [9:8] sit in bits [1:0] and the rate code sits in bits [7:4]. A read returns data one clock after the address is presented.
- R3: Some bits and addresses hold nothing. Bits [3:2] of a channel's second register always read zero, whatever was written. Enable bits at or above the channel count always read zero. Unmapped addresses read zero, and writes to them change no output.
- R4: One quantum lasts (32 − rate code) clock cycles, and a period lasts exactly 1024 quanta.
- R5: Within each period the output is high for (duty + 1) quanta, starting at the period's first cycle. A duty of 1023 keeps the output high continuously.
- R6: A channel whose enable bit is clear drives its output low. The output goes low in the cycle after the write that clears the bit.
- R7: Setting an enable bit starts a fresh period with the output high one cycle after the write. A disable followed by an enable restarts the period from its first quantum.
- R8: Rate and duty values written during a period take effect only at the next period boundary.
- R9: Channels run independently, each with its own rate code, duty and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; quanta are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
The hardest situation to create from the ports is a rate and duty rewrite that lands in the middle of a running period, while the old pulse is still high. A correct design finishes the current period with the old values and switches only at the boundary. The bench enables a channel, waits a few hundred cycles into its high phase, and rewrites both its duty and its rate code. It then counts high cycles over two whole windows, one period of each length, and compares them with the arithmetic expectation for the old and the new settings. A second difficult case is a disable in the middle of a period. The bench re-enables the channel a few cycles later and checks that the next window is a complete first period, which shows that the counters restarted.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int BYTE_W  = 8;
   localparam int RATE_W  = 4;
   localparam int DUTY_W  = 10;
   localparam int DIV_TOP = 32;
   localparam int PRE_W   = $clog2(DIV_TOP);
   localparam int LEN_W   = PRE_W + 1;

   typedef logic [RATE_W-1:0] rate_t;
   typedef logic [DUTY_W-1:0] duty_t;

   typedef struct packed {
      rate_t rate;
      duty_t duty;
   } chan_cfg_t;

   localparam duty_t DUTY_MAX = '1;

   function automatic logic [LEN_W-1:0] quantum_len(rate_t r);
      return LEN_W'(DIV_TOP) - LEN_W'(r);
   endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_wr,
   output logic [BYTE_W-1:0] bus_rdata,
   output chan_cfg_t         cfg [NUM_CH],
   output logic [NUM_CH-1:0] enable
);

   localparam int EN_ADDR  = 0;
   localparam int CH_BASE  = 1;
   localparam int TOP_ADDR = CH_BASE + 2 * NUM_CH - 1;
   localparam int HI_BITS  = DUTY_W - BYTE_W;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= BYTE_W)
         else $error("channel count must fit one enable byte");
      assert (TOP_ADDR < (1 << ADDR_W))
         else $error("address width too small for channel count");
   end

   function automatic logic [ADDR_W-1:0] lo_addr(int c);
      return ADDR_W'(CH_BASE + 2 * c);
   endfunction

   function automatic logic [ADDR_W-1:0] hi_addr(int c);
      return ADDR_W'(CH_BASE + 2 * c + 1);
   endfunction

   logic [BYTE_W-1:0] rd_next;
   logic              unused_wbits;

   assign unused_wbits = ^bus_wdata[RATE_W-1:HI_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= '0;
         for (int c = 0; c < NUM_CH; c++) begin
            cfg[c] <= '0;
         end
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(EN_ADDR)) begin
            enable <= bus_wdata[NUM_CH-1:0];
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == lo_addr(c)) begin
               cfg[c].duty[BYTE_W-1:0] <= bus_wdata;
            end
            if (bus_addr == hi_addr(c)) begin
               cfg[c].duty[DUTY_W-1:BYTE_W] <= bus_wdata[HI_BITS-1:0];
               cfg[c].rate <= bus_wdata[BYTE_W-1:BYTE_W-RATE_W];
            end
         end
      end
   end

   always_comb begin
      rd_next = '0;
      if (bus_addr == ADDR_W'(EN_ADDR)) begin
         rd_next[NUM_CH-1:0] = enable;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == lo_addr(c)) begin
            rd_next = cfg[c].duty[BYTE_W-1:0];
         end
         if (bus_addr == hi_addr(c)) begin
            rd_next = {cfg[c].rate, {(BYTE_W-RATE_W-HI_BITS){1'b0}},
                       cfg[c].duty[DUTY_W-1:BYTE_W]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= rd_next;
      end
   end

   // R3
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_addr) > ADDR_W'(TOP_ADDR)) |-> (bus_rdata == '0));

   // R3
   for (genvar c = 0; c < NUM_CH; c++) begin : g_rsv
      reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(bus_addr) == hi_addr(c)) |-> (bus_rdata[3:2] == 2'b00));
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  chan_cfg_t cfg,
   output logic      pwm
);

   chan_cfg_t        act;
   logic             running;
   logic [PRE_W-1:0] pre;
   duty_t            qcnt;
   logic [LEN_W-1:0] qlen;
   logic             pre_last;
   logic             q_last;

   assign qlen     = quantum_len(act.rate);
   assign pre_last = ({1'b0, pre} == qlen - 1'b1);
   assign q_last   = (qcnt == DUTY_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         pre     <= '0;
         qcnt    <= '0;
         act     <= '0;
      end else if (!en) begin
         running <= 1'b0;
         pre     <= '0;
         qcnt    <= '0;
      end else if (!running) begin
         running <= 1'b1;
         act     <= cfg;
         pre     <= '0;
         qcnt    <= '0;
      end else if (pre_last) begin
         pre <= '0;
         if (q_last) begin
            qcnt <= '0;
            act  <= cfg;
         end else begin
            qcnt <= qcnt + 1'b1;
         end
      end else begin
         pre <= pre + 1'b1;
      end
   end

   assign pwm = en && running && (qcnt <= act.duty);

   // R4
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> ({1'b0, pre} < qlen));

   // R8
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && en && !(pre_last && q_last)) |=> $stable(act));

   // R7
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(running) && en) |-> pwm);

   // R5
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && en && act.duty == DUTY_MAX) |-> pwm);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   output logic [7:0]        bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   chan_cfg_t         cfg [NUM_CH];
   logic [NUM_CH-1:0] enable;

   pwm_regfile #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .cfg       (cfg),
      .enable    (enable)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_chan u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (enable[c]),
         .cfg   (cfg[c]),
         .pwm   (pwm_out[c])
      );

      // R6
      dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !enable[c] |-> !pwm_out[c]);
   end

endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 3;
   localparam int AW         = 4;
   localparam int QN         = 1024;
   localparam int WATCHDOG   = 180000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  bus_addr = '0;
   logic [7:0]     bus_wdata = '0;
   logic           bus_wr = 1'b0;
   logic [7:0]     bus_rdata;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_wdata = 8'(d);
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      @(negedge clk);
      bus_addr = AW'(a);
      @(negedge clk);
      chk(bus_rdata == 8'(exp), req, $sformatf("read addr %0d", a),
          int'(bus_rdata), exp);
   endtask

   task automatic set_ch(input int ch, input int rate, input int duty);
      wr(1 + 2 * ch, duty & 8'hff);
      wr(2 + 2 * ch, (rate << 4) | ((duty >> 8) & 3));
   endtask

   task automatic wait_rise(input int ch);
      while (!pwm_out[ch]) @(negedge clk);
   endtask

   // Called on the first high cycle of a period; counts one full period.
   task automatic window(input int ch, input int rate, input int duty,
                         input string req);
      int p;
      int h;
      p = QN * (32 - rate);
      h = 0;
      for (int i = 0; i < p; i++) begin
         if (pwm_out[ch]) h++;
         @(negedge clk);
      end
      chk(h == (duty + 1) * (32 - rate), req,
          $sformatf("ch%0d high cycles per period", ch), h, (duty + 1) * (32 - rate));
      chk(pwm_out[ch] == 1'b1, "R4", $sformatf("ch%0d next period starts high", ch),
          int'(pwm_out[ch]), 1);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int low_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(pwm_out == '0, "R1", "outputs after reset", int'(pwm_out), 0);
      for (int a = 0; a < 16; a++) rd_chk(a, 0, "R1");

      // R2 and R3: readback and reserved bits
      wr(1, 8'hA5); wr(2, 8'hFF);
      wr(3, 8'h3C); wr(4, 8'h5E);
      wr(5, 8'h01); wr(6, 8'h0C);
      rd_chk(1, 8'hA5, "R2"); rd_chk(2, 8'hF3, "R3");
      rd_chk(3, 8'h3C, "R2"); rd_chk(4, 8'h52, "R2");
      rd_chk(5, 8'h01, "R2"); rd_chk(6, 8'h00, "R3");
      wr(0, 8'hF8);
      rd_chk(0, 0, "R3");
      wr(7, 8'hFF); wr(15, 8'hFF);
      rd_chk(7, 0, "R3"); rd_chk(15, 0, "R3");
      repeat (40) @(negedge clk);
      chk(pwm_out == '0, "R3", "outputs after writes to unused bits", int'(pwm_out), 0);
      wr(0, 8'h05);
      rd_chk(0, 5, "R2");
      wr(0, 8'h00);
      rd_chk(0, 0, "R2");

      // R4, R5, R9: three independent channels in parallel
      set_ch(0, 15, 0);
      set_ch(1, 8, 1023);
      set_ch(2, 0, 511);
      wr(0, 8'h07);
      chk(pwm_out == '0, "R7", "outputs before start cycle", int'(pwm_out), 0);
      @(negedge clk);
      chk(pwm_out == 3'b111, "R7", "outputs high one cycle after enable",
          int'(pwm_out), 7);
      fork
         window(0, 15, 0, "R5");
         window(1, 8, 1023, "R5");
         window(2, 0, 511, "R9");
      join

      // R6: disable drops outputs in the cycle after the write
      wr(0, 8'h00);
      chk(pwm_out == '0, "R6", "outputs after disable", int'(pwm_out), 0);
      low_cnt = 0;
      for (int i = 0; i < 100; i++) begin
         if (pwm_out == '0) low_cnt++;
         @(negedge clk);
      end
      chk(low_cnt == 100, "R6", "low cycles while disabled", low_cnt, 100);

      // R8: mid-period rewrite applies at the boundary
      set_ch(0, 15, 99);
      wr(0, 8'h01);
      wait_rise(0);
      fork
         begin
            window(0, 15, 99, "R8");
            window(0, 14, 9, "R8");
         end
         begin
            repeat (200) @(negedge clk);
            set_ch(0, 14, 9);
         end
      join

      // R7: disable mid-period then re-enable restarts from quantum 0
      set_ch(0, 15, 199);
      wr(0, 8'h00);
      wr(0, 8'h01);
      wait_rise(0);
      repeat (1000) @(negedge clk);
      wr(0, 8'h00);
      chk(pwm_out[0] == 1'b0, "R6", "ch0 low after mid-period disable",
          int'(pwm_out[0]), 0);
      repeat (5) @(negedge clk);
      wr(0, 8'h01);
      chk(pwm_out[0] == 1'b0, "R7", "ch0 before restart cycle", int'(pwm_out[0]), 0);
      @(negedge clk);
      chk(pwm_out[0] == 1'b1, "R7", "ch0 high on restart", int'(pwm_out[0]), 1);
      window(0, 15, 199, "R7");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule